// File: doc/BRIEF.md
# 1-Wire Reset and Time-Slot Generator

This block drives one open-drain 1-Wire line. On a start strobe it produces either a complete bus reset with presence detection or a single bit time slot: write-zero, or write-one, which doubles as a read slot. Every duration is counted in 50 ns time-base ticks. A fractional prescaler derives these ticks from the system clock, so standard and overdrive timing both come out exact. When the operation ends, the block reports the sampled bit, a presence flag and a short flag. It then holds these results until an operation of the same kind replaces them.

Three pullup and masking aids sit next to the plain line pulldown:
- an active-pullup enable that stays on for a fixed time after the master releases the line;
- a second pulldown that masks the falling edge of the presence pulse at standard speed;
- a strong pullup with an active-low external FET control. It switches on when a slot ends and stays on until the next command, an explicit cancel, or a device reset.

The options are sampled when the operation starts.

A host-side controller uses the block by issuing one start strobe per operation and waiting for `done_o`. Slow analog effects such as slew control and threshold crossing belong outside the block. The active pullup is only a timed enable.

Top module: `ow_slot_gen`

## Requirements
- R1: A reset operation (`op_i`=0) asserts `line_pd_o` from the first cycle after the accepted start for 12000 ticks (600 µs) at standard speed, or 1440 ticks (72 µs) with `overdrive_i`=1.
- R2: `busy_o` is high from the cycle after an accepted start for the whole operation: 23680 ticks for reset at standard speed, 2920 at overdrive. `done_o` pulses for exactly one cycle, in the first cycle with `busy_o` low.
- R3: If the line reads low 160 ticks (8 µs) after the reset pulldown ends, or 15 ticks (0.75 µs) at overdrive, the operation reports `short_o`=1 and forces `presence_o`=0.
- R4: `presence_o` reports a low line sampled 1400 ticks (70 µs) after the reset pulldown ends, or 150 ticks (7.5 µs) at overdrive.
- R5: With `ppm_i`=1 at standard speed, `mask_pd_o` pulls low from 200 to 1200 ticks (10 µs to 60 µs) after the reset pulldown ends. At overdrive, `ppm_i` has no effect.
- R6: A slot lasts 1386 ticks (69.3 µs) at standard speed and 210 ticks (10.5 µs) at overdrive. A write-zero slot (`op_i`=1) holds the pulldown for 1280 ticks (64 µs) or 150 ticks (7.5 µs), and its `bit_o` reads 0.
- R7: A write-one/read slot (`op_i`=2) holds the pulldown for 160 ticks (8 µs) or 20 ticks (1 µs). It sets `bit_o` to the line level sampled at 280 ticks (14 µs) or 30 ticks (1.5 µs).
- R8: `apu_en_o` is high for 50 ticks (2.5 µs), or 10 ticks at overdrive, starting where the block's own pulldown ends. This happens only when `apu_i`=1, or in a slot with `spu_i`=1. It never appears during the presence pulse or after the mask pulldown, so each operation has at most one pulse.
- R9: After a slot started with `spu_i`=1, `spu_en_o` rises together with `done_o` and `fet_n_o` goes low. Both hold until the next accepted start, a `spu_cancel_i` pulse, or `dev_rst_i`. A reset operation ignores `spu_i`.
- R10: A start while `busy_o` is high, and a start with `op_i`=3, are ignored and do not change the line or the operation in progress.
- R11: After `rst_ni` or one cycle of `dev_rst_i`, the line is released, `busy_o`, `apu_en_o`, `spu_en_o`, `bit_o`, `presence_o` and `short_o` are 0, and `fet_n_o` is 1. A device reset aborts an operation in progress on the next clock.
- R12: `presence_o` and `short_o` change only at the end of reset operations. `bit_o` changes only at the end of slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_rst_i | input | 1 | Synchronous device reset; aborts any operation |
| start_i | input | 1 | Start strobe |
| op_i | input | 2 | 0 reset, 1 write-zero, 2 write-one/read, 3 invalid |
| overdrive_i | input | 1 | Overdrive timing for the started operation |
| apu_i | input | 1 | Active pullup enable |
| ppm_i | input | 1 | Presence-pulse masking enable |
| spu_i | input | 1 | Strong pullup after the slot |
| spu_cancel_i | input | 1 | Ends the strong pullup |
| line_i | input | 1 | Line level (asynchronous, synchronised inside) |
| line_pd_o | output | 1 | Master pulldown of the line |
| mask_pd_o | output | 1 | Presence-mask pulldown |
| apu_en_o | output | 1 | Active pullup enable |
| spu_en_o | output | 1 | Strong pullup enable |
| fet_n_o | output | 1 | Active-low external FET control |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| bit_o | output | 1 | Sampled slot bit |
| presence_o | output | 1 | Presence detected |
| short_o | output | 1 | Short detected |

## Verification
The hardest situation to reach is a masked presence sequence at standard speed. In it, three pulldowns and the active pullup follow each other within a few hundred ticks of the reset release, while a modelled slave pulls the line low at its own time. The bench runs the prescaler at one tick per clock and measures each output's first cycle and length against the tick table. A slave model keyed to the cycle count since the start strobe overlaps the mask window and still covers the presence sample point. Aborts and ignored starts are injected at fixed offsets inside an operation in progress.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;
  localparam int TW = 16;

  typedef enum logic [1:0] {
    OP_RESET  = 2'd0,
    OP_WRITE0 = 2'd1,
    OP_WRITE1 = 2'd2,
    OP_NONE   = 2'd3
  } ow_op_e;

  typedef enum logic [1:0] {PH_IDLE, PH_RESET, PH_SLOT} ow_phase_e;

  // all points in 50 ns ticks, counted from the start of the operation
  typedef struct packed {
    logic [TW-1:0] rst_low;
    logic [TW-1:0] rst_end;
    logic [TW-1:0] short_at;
    logic [TW-1:0] pres_at;
    logic [TW-1:0] mask_on;
    logic [TW-1:0] mask_off;
    logic [TW-1:0] slot_end;
    logic [TW-1:0] w0_low;
    logic [TW-1:0] w1_low;
    logic [TW-1:0] samp_at;
    logic [TW-1:0] apu_len;
  } ow_timing_t;

  function automatic ow_timing_t ow_timing(input logic od);
    ow_timing_t t;
    if (od) begin
      t.rst_low  = 16'd1440;
      t.rst_end  = 16'd2920;
      t.short_at = 16'd1455;
      t.pres_at  = 16'd1590;
      t.mask_on  = 16'd0;
      t.mask_off = 16'd0;
      t.slot_end = 16'd210;
      t.w0_low   = 16'd150;
      t.w1_low   = 16'd20;
      t.samp_at  = 16'd30;
      t.apu_len  = 16'd10;
    end else begin
      t.rst_low  = 16'd12000;
      t.rst_end  = 16'd23680;
      t.short_at = 16'd12160;
      t.pres_at  = 16'd13400;
      t.mask_on  = 16'd12200;
      t.mask_off = 16'd13200;
      t.slot_end = 16'd1386;
      t.w0_low   = 16'd1280;
      t.w1_low   = 16'd160;
      t.samp_at  = 16'd280;
      t.apu_len  = 16'd50;
    end
    return t;
  endfunction
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int CLK_KHZ  = 125000,
  parameter int TICK_KHZ = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int AW = $clog2(CLK_KHZ + 1);
  localparam int SW = AW + 1;
  localparam logic [SW-1:0] INC = SW'(TICK_KHZ);
  localparam logic [SW-1:0] MOD = SW'(CLK_KHZ);

  logic [AW-1:0] acc_q;
  logic [SW-1:0] sum;

  // fractional divider: exact average tick rate for any clock
  assign sum    = {1'b0, acc_q} + INC;
  assign tick_o = (sum >= MOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= AW'(tick_o ? sum - MOD : sum);
  end
endmodule

// File: rtl/ow_slot_seq.sv
module ow_slot_seq
  import ow_slot_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          abort_i,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          od_i,
  input  logic          apu_i,
  input  logic          ppm_i,
  input  logic          spu_i,
  input  logic          line_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          accept_o,
  output logic          pull_low_o,
  output logic          mask_low_o,
  output logic          release_o,
  output logic          finish_spu_o,
  output logic          apu_go_o,
  output logic [TW-1:0] apu_len_o,
  output logic          bit_o,
  output logic          presence_o,
  output logic          short_o
);
  ow_phase_e     phase_q;
  logic [TW-1:0] t_q;
  logic          od_q, ppm_q, apu_q, spu_q, wr0_q;
  logic          done_q, bit_q, pres_q, short_q;
  logic          smp_pres_q, smp_short_q, smp_bit_q;

  ow_timing_t    tm;
  logic          is_rst, last;
  logic [TW-1:0] low_end, end_t;

  assign tm      = ow_timing(od_q);
  assign is_rst  = (phase_q == PH_RESET);
  assign busy_o  = (phase_q != PH_IDLE);
  assign low_end = is_rst ? tm.rst_low : (wr0_q ? tm.w0_low : tm.w1_low);
  assign end_t   = is_rst ? tm.rst_end : tm.slot_end;
  assign last    = busy_o && tick_i && (t_q == end_t - 16'd1);

  assign accept_o     = start_i && !busy_o && (op_i != OP_NONE) && !abort_i;
  assign pull_low_o   = busy_o && (t_q < low_end);
  assign mask_low_o   = is_rst && ppm_q && !od_q && (t_q >= tm.mask_on) && (t_q < tm.mask_off);
  assign release_o    = busy_o && tick_i && (t_q == low_end - 16'd1);
  assign finish_spu_o = last && !is_rst && spu_q;
  assign apu_go_o     = apu_q || (!is_rst && spu_q);
  assign apu_len_o    = tm.apu_len;

  assign done_o     = done_q;
  assign bit_o      = bit_q;
  assign presence_o = pres_q;
  assign short_o    = short_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      t_q         <= '0;
      od_q        <= 1'b0;
      ppm_q       <= 1'b0;
      apu_q       <= 1'b0;
      spu_q       <= 1'b0;
      wr0_q       <= 1'b0;
      done_q      <= 1'b0;
      bit_q       <= 1'b0;
      pres_q      <= 1'b0;
      short_q     <= 1'b0;
      smp_pres_q  <= 1'b0;
      smp_short_q <= 1'b0;
      smp_bit_q   <= 1'b0;
    end else if (abort_i) begin
      phase_q     <= PH_IDLE;
      t_q         <= '0;
      done_q      <= 1'b0;
      bit_q       <= 1'b0;
      pres_q      <= 1'b0;
      short_q     <= 1'b0;
      smp_pres_q  <= 1'b0;
      smp_short_q <= 1'b0;
      smp_bit_q   <= 1'b0;
    end else begin
      done_q <= last;
      if (accept_o) begin
        phase_q     <= (op_i == OP_RESET) ? PH_RESET : PH_SLOT;
        t_q         <= '0;
        od_q        <= od_i;
        ppm_q       <= ppm_i;
        apu_q       <= apu_i;
        spu_q       <= spu_i;
        wr0_q       <= (op_i == OP_WRITE0);
        smp_pres_q  <= 1'b0;
        smp_short_q <= 1'b0;
        smp_bit_q   <= 1'b0;
      end else if (busy_o && tick_i) begin
        t_q <= t_q + 16'd1;
        if (is_rst) begin
          if (t_q == tm.short_at) smp_short_q <= !line_i;
          if (t_q == tm.pres_at)  smp_pres_q  <= !line_i;
        end else if (t_q == tm.samp_at) begin
          smp_bit_q <= line_i;
        end
        if (last) begin
          phase_q <= PH_IDLE;
          if (is_rst) begin
            pres_q  <= smp_pres_q && !smp_short_q;
            short_q <= smp_short_q;
          end else begin
            bit_q <= smp_bit_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ow_pullup_ctl.sv
module ow_pullup_ctl
  import ow_slot_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          abort_i,
  input  logic          accept_i,
  input  logic          cancel_i,
  input  logic          release_i,
  input  logic          apu_go_i,
  input  logic [TW-1:0] apu_len_i,
  input  logic          finish_spu_i,
  output logic          apu_en_o,
  output logic          spu_en_o
);
  logic [TW-1:0] apu_cnt_q;
  logic          spu_q;

  assign apu_en_o = (apu_cnt_q != '0);
  assign spu_en_o = spu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       apu_cnt_q <= '0;
    else if (abort_i || accept_i)      apu_cnt_q <= '0;
    else if (release_i && apu_go_i)    apu_cnt_q <= apu_len_i;
    else if (tick_i && apu_en_o)       apu_cnt_q <= apu_cnt_q - 16'd1;
  end

  // strong pullup holds until the next command, a cancel or a device reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                spu_q <= 1'b0;
    else if (abort_i || accept_i || cancel_i)   spu_q <= 1'b0;
    else if (finish_spu_i)                      spu_q <= 1'b1;
  end
endmodule

// File: rtl/ow_slot_gen.sv
module ow_slot_gen
  import ow_slot_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int TICK_KHZ    = 20000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dev_rst_i,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       overdrive_i,
  input  logic       apu_i,
  input  logic       ppm_i,
  input  logic       spu_i,
  input  logic       spu_cancel_i,
  input  logic       line_i,
  output logic       line_pd_o,
  output logic       mask_pd_o,
  output logic       apu_en_o,
  output logic       spu_en_o,
  output logic       fet_n_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       bit_o,
  output logic       presence_o,
  output logic       short_o
);
  logic          tick, line_s, accept, release_ev, finish_spu, apu_go;
  logic [TW-1:0] apu_len;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = line_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= SYNC_STAGES'({sh_q, line_i});
      end
      assign line_s = sh_q[SYNC_STAGES-1];
    end
  endgenerate

  ow_tick_gen #(.CLK_KHZ(CLK_KHZ), .TICK_KHZ(TICK_KHZ)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ow_slot_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .abort_i     (dev_rst_i),
    .start_i     (start_i),
    .op_i        (op_i),
    .od_i        (overdrive_i),
    .apu_i       (apu_i),
    .ppm_i       (ppm_i),
    .spu_i       (spu_i),
    .line_i      (line_s),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .accept_o    (accept),
    .pull_low_o  (line_pd_o),
    .mask_low_o  (mask_pd_o),
    .release_o   (release_ev),
    .finish_spu_o(finish_spu),
    .apu_go_o    (apu_go),
    .apu_len_o   (apu_len),
    .bit_o       (bit_o),
    .presence_o  (presence_o),
    .short_o     (short_o)
  );

  ow_pullup_ctl u_pull (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .abort_i     (dev_rst_i),
    .accept_i    (accept),
    .cancel_i    (spu_cancel_i),
    .release_i   (release_ev),
    .apu_go_i    (apu_go),
    .apu_len_i   (apu_len),
    .finish_spu_i(finish_spu),
    .apu_en_o    (apu_en_o),
    .spu_en_o    (spu_en_o)
  );

  assign fet_n_o = !spu_en_o;
endmodule

// File: rtl/ow_slot_gen_chk.sv
module ow_slot_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dev_rst_i,
  input logic       start_i,
  input logic [1:0] op_i,
  input logic       line_pd_o,
  input logic       mask_pd_o,
  input logic       apu_en_o,
  input logic       spu_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       presence_o,
  input logic       short_o
);
  a_r1_pd_in_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_pd_o |-> busy_o);
  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r3_short_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> !presence_o);
  a_r5_mask_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_pd_o |-> (busy_o && !line_pd_o));
  a_r8_apu_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apu_en_o |-> (!line_pd_o && !mask_pd_o));
  a_r9_spu_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spu_en_o) |-> done_o);
  a_r9_spu_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spu_en_o |-> !busy_o);
  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !dev_rst_i) |=> (busy_o || done_o));
  a_r11_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_i |=> (!busy_o && !line_pd_o && !spu_en_o && !apu_en_o));
endmodule

bind ow_slot_gen ow_slot_gen_chk u_chk (.*);

// File: tb/ow_slot_gen_tb.sv
module ow_slot_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dev_rst = 0, start = 0, od = 0, apu = 0, ppm = 0, spu = 0, spu_cancel = 0;
  logic [1:0] op = 2'd0;
  logic line, line_pd, mask_pd, apu_en, spu_en, fet_n, busy, done, bit_v, pres, shrt;

  int total = 0, fails = 0;
  int op_cyc = 0, sl_lo = 0, sl_hi = 0;
  int n_busy, n_pd, n_mask, mask_first, n_apu, apu_first, apu_rises, n_done;
  logic spu_at0;

  always #4 clk = ~clk;

  always @(posedge clk) op_cyc <= start ? 0 : op_cyc + 1;
  assign line = !(line_pd || mask_pd || (op_cyc >= sl_lo && op_cyc < sl_hi));

  ow_slot_gen #(.CLK_KHZ(125000), .TICK_KHZ(125000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dev_rst_i(dev_rst), .start_i(start), .op_i(op),
    .overdrive_i(od), .apu_i(apu), .ppm_i(ppm), .spu_i(spu), .spu_cancel_i(spu_cancel),
    .line_i(line), .line_pd_o(line_pd), .mask_pd_o(mask_pd), .apu_en_o(apu_en),
    .spu_en_o(spu_en), .fet_n_o(fet_n), .busy_o(busy), .done_o(done), .bit_o(bit_v),
    .presence_o(pres), .short_o(shrt));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic s_od, s_apu, s_ppm, s_spu, input int inj_at);
    logic prev_apu = 1'b0;
    @(negedge clk);
    op = o; od = s_od; apu = s_apu; ppm = s_ppm; spu = s_spu; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_busy = 0; n_pd = 0; n_mask = 0; mask_first = -1; n_apu = 0; apu_first = -1;
    apu_rises = 0; n_done = 0; spu_at0 = spu_en;
    for (int n = 0; n < 30000; n++) begin
      if (n > 0) @(negedge clk);
      if (n == inj_at) begin op = 2'd1; start = 1'b1; end
      if (n == inj_at + 1) start = 1'b0;
      if (busy) n_busy++;
      if (line_pd) n_pd++;
      if (mask_pd) begin if (mask_first < 0) mask_first = n; n_mask++; end
      if (apu_en) begin if (apu_first < 0) apu_first = n; n_apu++; if (!prev_apu) apu_rises++; end
      prev_apu = apu_en;
      if (done) n_done++;
      if (!busy) break;
    end
    @(negedge clk);
    if (done) n_done++;
  endtask

  task automatic t_reset_state;
    chk("R11 busy after reset", int'(busy), 0);
    chk("R11 line released after reset", int'(line_pd || mask_pd), 0);
    chk("R11 fet_n after reset", int'(fet_n), 1);
    chk("R11 results after reset", int'({bit_v, pres, shrt, apu_en, spu_en}), 0);
  endtask

  task automatic t_std_presence_masked;
    sl_lo = 12400; sl_hi = 13600;
    run_op(2'd0, 1'b0, 1'b1, 1'b1, 1'b0, -1);
    chk("R1 std reset low", n_pd, 12000);
    chk("R2 std reset busy", n_busy, 23680);
    chk("R2 done pulses", n_done, 1);
    chk("R4 std presence", int'(pres), 1);
    chk("R3 no short", int'(shrt), 0);
    chk("R5 mask length", n_mask, 1000);
    chk("R5 mask start", mask_first, 12200);
    chk("R8 apu length std", n_apu, 50);
    chk("R8 apu start std", apu_first, 12000);
    chk("R8 one apu pulse", apu_rises, 1);
    sl_lo = 0; sl_hi = 0;
  endtask

  task automatic t_std_absent;
    run_op(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    chk("R4 no presence", int'(pres), 0);
    chk("R5 no mask with ppm off", n_mask, 0);
    chk("R8 no apu with apu off", n_apu, 0);
    chk("R9 spu ignored on reset", int'(spu_en), 0);
  endtask

  task automatic t_std_short;
    sl_lo = 0; sl_hi = 1000000000;
    run_op(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    chk("R3 short flag", int'(shrt), 1);
    chk("R3 short forces no presence", int'(pres), 0);
    sl_hi = 0;
  endtask

  task automatic t_od_reset;
    sl_lo = 1480; sl_hi = 1640;
    run_op(2'd0, 1'b1, 1'b1, 1'b1, 1'b0, -1);
    chk("R1 od reset low", n_pd, 1440);
    chk("R2 od reset busy", n_busy, 2920);
    chk("R4 od presence", int'(pres), 1);
    chk("R3 od no short", int'(shrt), 0);
    chk("R5 ppm ignored at od", n_mask, 0);
    chk("R8 apu length od", n_apu, 10);
    chk("R8 apu start od", apu_first, 1440);
    sl_hi = 0;
  endtask

  task automatic t_slots;
    run_op(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, -1);
    chk("R6 od write0 low", n_pd, 150);
    chk("R6 od slot length", n_busy, 210);
    chk("R6 write0 bit", int'(bit_v), 0);
    chk("R8 apu after write0", apu_first, 150);
    run_op(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    chk("R7 std write1 low", n_pd, 160);
    chk("R6 std slot length", n_busy, 1386);
    chk("R7 read high", int'(bit_v), 1);
    sl_lo = 0; sl_hi = 60;
    run_op(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, -1);
    sl_hi = 0;
    chk("R7 od write1 low", n_pd, 20);
    chk("R7 read low", int'(bit_v), 0);
    chk("R12 presence kept over slots", int'(pres), 1);
    run_op(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, -1);
    chk("R12 presence updated by reset", int'(pres), 0);
    chk("R12 bit kept over reset", int'(bit_v), 0);
  endtask

  task automatic t_spu;
    run_op(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, -1);
    chk("R8 spu forces apu", n_apu, 10);
    chk("R8 spu apu start", apu_first, 20);
    chk("R9 spu on after slot", int'(spu_en), 1);
    chk("R9 fet low", int'(fet_n), 0);
    repeat (100) @(negedge clk);
    chk("R9 spu holds", int'(spu_en), 1);
    run_op(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, -1);
    chk("R9 next command ends spu", int'(spu_at0), 0);
    chk("R9 spu stays off", int'(spu_en), 0);
    run_op(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, -1);
    @(negedge clk); spu_cancel = 1'b1;
    @(negedge clk); spu_cancel = 1'b0;
    chk("R9 cancel ends spu", int'(spu_en), 0);
    chk("R9 fet high after cancel", int'(fet_n), 1);
  endtask

  task automatic t_ignored;
    run_op(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 100);
    chk("R10 start while busy ignored (busy)", n_busy, 2920);
    chk("R10 start while busy ignored (pd)", n_pd, 1440);
    @(negedge clk); op = 2'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 op 3 ignored busy", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk("R10 op 3 ignored line", int'(line_pd), 0);
  endtask

  task automatic t_abort;
    sl_lo = 1480; sl_hi = 1640;
    run_op(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, -1);
    sl_hi = 0;
    @(negedge clk); op = 2'd0; od = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (500) @(negedge clk);
    chk("R11 reset running before abort", int'(line_pd), 1);
    dev_rst = 1'b1;
    @(negedge clk); dev_rst = 1'b0;
    chk("R11 abort releases line", int'(line_pd), 0);
    chk("R11 abort clears busy", int'(busy), 0);
    chk("R11 abort clears presence", int'(pres), 0);
    run_op(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, -1);
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk); dev_rst = 1'b0;
    chk("R11 abort ends spu", int'(spu_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state;
    t_std_presence_masked;
    t_std_absent;
    t_std_short;
    t_od_reset;
    t_slots;
    t_spu;
    t_ignored;
    t_abort;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule